// File: doc/BRIEF.md
# GPIO interrupt channel multiplexer

This block picks a small set of pad inputs out of a large pad bank and turns each into an interrupt request for a parent interrupt controller. The parent only accepts active-high levels and rising edges. Each of the eight output channels has three parts: a pad-select field, a trigger mode, and an optional inversion. With these, low-level and falling-edge sources still reach the parent as active-high requests. A both-edges mode reports every change of the selected pad. When it is enabled, it overrides the other trigger bits of that channel.

Software programs the block through a plain synchronous register port with 32-bit data. Every pad passes through a two-flop synchroniser before the channel multiplexers. Each channel then registers its result. A level channel drives a steady high while its condition holds. An edge channel drives a single-cycle pulse. A write to a channel's configuration never produces a spurious pulse.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset, every register reads zero, every channel is in level-high mode selecting pad 0, and all interrupt outputs are low while the pads are low.
- R2: Register 0x00 holds the trigger bits. Bit n (n = 0..7) is edge mode for channel n, bit 8+n is both-edges, and bit 16+n is inversion. Bits 24..31 always read zero. Registers 0x04 and 0x08 hold the 8-bit pad selects for channels 0..3 and 4..7, at bit (n mod 4)*8 of their word.
- R3: Register 0x0C is a 32-bit read/write filter setting with a 4-bit field per channel at bit 4n. Its value has no effect on any interrupt output.
- R4: Any word offset from 0x10 upward reads zero. Read data for the offset on the address lines appears after the next rising clock edge.
- R5: A channel with edge, both-edges and inversion bits clear (level high) drives its output equal to the selected pad. The output changes on the third rising edge after the pad changes.
- R6: A channel in level mode with inversion set (level low) drives the complement of the selected pad.
- R7: A channel with edge mode set and inversion clear drives a one-cycle pulse for each rising transition of the selected pad. The pulse is high during the cycle after the third rising edge following the pad change.
- R8: A channel with edge mode and inversion both set drives a one-cycle pulse for each falling transition of the selected pad.
- R9: A channel with the both-edges bit set pulses for one cycle on every transition of the selected pad, whatever its edge-mode and inversion bits say.
- R10: In the cycle after a write to the trigger register or to a channel's pad-select register, no edge or both-edges channel affected by that write produces a pulse.
- R11: Channels that select the same pad are evaluated independently, each according to its own trigger bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register (bits 1:0 ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the previous cycle's reg_addr |
| pad_in | input | 256 | Asynchronous pad inputs |
| irq_out | output | 8 | Active-high interrupt request per channel |

## Verification
A pad change driven between clock edges reaches irq_out on the third rising edge: two synchroniser stages, then the registered channel result. A register write changes the channel behaviour from the next edge, and read data follows the address by one edge. The bench drives inputs and samples outputs on falling edges. It keeps a cycle model of the pad pipeline and the register copies, clocked on the same rising edge as the design, so each expected value lines up with the exact cycle it is due. Directed sequences step edge by edge and check the output is low before the due cycle, high on it, and low again after it.

// File: rtl/gim_pkg.sv
package gim_pkg;
    // Per-channel trigger configuration
    typedef struct packed {
        logic edge_en;  // edge detection instead of level
        logic both_en;  // pulse on every transition, overrides the others
        logic inv_en;   // invert selected pad (low level / falling edge)
    } trig_t;

    localparam int REG_W = 32;
    localparam int FILT_BITS = 4;
endpackage

// File: rtl/gim_sync.sv
module gim_sync #(
    parameter int WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/gim_regs.sv
module gim_regs
    import gim_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [REG_W-1:0]               wdata_i,
    output logic [REG_W-1:0]               rdata_o,
    output trig_t [NUM_CH-1:0]             trig_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]   sel_o,
    output logic [NUM_CH-1:0]              reload_o
);
    localparam int PER_REG   = REG_W / SEL_W;
    localparam int NSEL      = (NUM_CH + PER_REG - 1) / PER_REG;
    localparam int FILT_IDX  = NSEL + 1;
    localparam int WIDX_W    = ADDR_W - 2;
    localparam logic [REG_W-1:0] TRIG_MASK = REG_W'((64'd1 << (3 * NUM_CH)) - 64'd1);

    logic [WIDX_W-1:0] widx;
    logic [REG_W-1:0]  trig_q;
    logic [REG_W-1:0]  sel_q [NSEL];
    logic [REG_W-1:0]  filt_q;
    logic [REG_W-1:0]  rd_next;

    assign widx = addr_i[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q   <= '0;
            filt_q   <= '0;
            reload_o <= '0;
            for (int k = 0; k < NSEL; k++) sel_q[k] <= '0;
        end else begin
            reload_o <= '0;
            if (we_i) begin
                if (int'(widx) == 0) begin
                    trig_q   <= wdata_i & TRIG_MASK;
                    reload_o <= '1;
                end
                for (int k = 0; k < NSEL; k++) begin
                    if (int'(widx) == k + 1) begin
                        sel_q[k] <= wdata_i;
                        for (int j = 0; j < PER_REG; j++)
                            if (k * PER_REG + j < NUM_CH)
                                reload_o[k * PER_REG + j] <= 1'b1;
                    end
                end
                if (int'(widx) == FILT_IDX) filt_q <= wdata_i;
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (int'(widx) == 0) rd_next = trig_q;
        for (int k = 0; k < NSEL; k++)
            if (int'(widx) == k + 1) rd_next = sel_q[k];
        if (int'(widx) == FILT_IDX) rd_next = filt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_o <= '0;
        else     rdata_o <= rd_next;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fields
        assign trig_o[ch].edge_en = trig_q[ch];
        assign trig_o[ch].both_en = trig_q[NUM_CH + ch];
        assign trig_o[ch].inv_en  = trig_q[2 * NUM_CH + ch];
        assign sel_o[ch] = sel_q[ch / PER_REG][(ch % PER_REG) * SEL_W +: SEL_W];
    end

    // R2: a trigger write lands with the upper bits cleared
    p_trig_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we_i && int'(widx) == 0) |=> (trig_o[0].edge_en == $past(wdata_i[0]))
                                      && (rdata_o[31:24] == 8'h00 || int'($past(widx)) != 0));
    // R4: offsets past the filter register read zero
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (int'(widx) > FILT_IDX) |=> (rdata_o == '0));
    // R10: every write to the trigger register requests a history reload on all channels
    p_reload_all_r10: assert property (@(posedge clk) disable iff (rst)
        (we_i && int'(widx) == 0) |=> (&reload_o));
endmodule

// File: rtl/gim_chan.sv
module gim_chan
    import gim_pkg::*;
#(
    parameter int SEL_W    = 8,
    parameter int NUM_PADS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pads_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  trig_t               trig_i,
    input  logic                reload_i,
    output logic                irq_o
);
    logic raw, hist_q, cur_v, prev_v, fire;

    assign raw    = pads_i[sel_i];
    assign cur_v  = raw ^ trig_i.inv_en;
    assign prev_v = hist_q ^ trig_i.inv_en;

    always_comb begin
        if (trig_i.both_en)      fire = (raw != hist_q) && !reload_i;
        else if (trig_i.edge_en) fire = cur_v && !prev_v && !reload_i;
        else                     fire = cur_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            hist_q <= raw;
            irq_o  <= fire;
        end
    end

    // R10: no pulse in the cycle after a configuration write
    p_quiet_after_cfg_r10: assert property (@(posedge clk) disable iff (rst)
        (reload_i && (trig_i.edge_en || trig_i.both_en)) |=> !irq_o);
    // R7: an edge-type pulse needs an actual change of the selected pad
    p_pulse_needs_change_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(trig_i.edge_en || trig_i.both_en) && irq_o) |-> $past(raw != hist_q));
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
    import gim_pkg::*;
#(
    parameter  int NUM_CH   = 8,
    parameter  int PAD_W    = 8,
    parameter  int ADDR_W   = 5,
    localparam int NUM_PADS = 1 << PAD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_CH-1:0]   irq_out
);
    logic [NUM_PADS-1:0]             pad_s;
    trig_t [NUM_CH-1:0]              trig;
    logic [NUM_CH-1:0][PAD_W-1:0]    sel;
    logic [NUM_CH-1:0]               reload;

    gim_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk(clk), .rst(rst), .d_i(pad_in), .q_o(pad_s)
    );

    gim_regs #(.NUM_CH(NUM_CH), .SEL_W(PAD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .trig_o(trig), .sel_o(sel), .reload_o(reload)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gim_chan #(.SEL_W(PAD_W), .NUM_PADS(NUM_PADS)) u_chan (
            .clk(clk), .rst(rst), .pads_i(pad_s), .sel_i(sel[ch]),
            .trig_i(trig[ch]), .reload_i(reload[ch]), .irq_o(irq_out[ch])
        );
    end

    // R1: outputs stay low through reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq_out == '0 && reg_rdata == '0));
endmodule

// File: tb/sim_gpio_irq_mux.sv
module sim_gpio_irq_mux;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [255:0] pad_in = '0;
    logic [7:0]   irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    bit live = 0;

    gpio_irq_mux u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model built from the requirements
    logic [255:0] m_s1, m_s2;
    logic [7:0]   m_h, m_out, m_rel;
    logic [31:0]  m_trig;
    logic [7:0]   m_sel [8];

    function automatic logic expect_out(input logic e, b, i, cur, prev, rel);
        if (b) return (cur != prev) && !rel;                 // R9
        if (e && !i) return cur && !prev && !rel;            // R7
        if (e && i)  return !cur && prev && !rel;            // R8
        return i ? !cur : cur;                               // R5 / R6
    endfunction

    function automatic string mode_tag(input int ch);
        if (m_trig[8 + ch]) return "R9";
        if (m_trig[ch]) return m_trig[16 + ch] ? "R8" : "R7";
        return m_trig[16 + ch] ? "R6" : "R5";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_h <= '0; m_out <= '0; m_rel <= '0; m_trig <= '0;
            for (int c = 0; c < 8; c++) m_sel[c] <= '0;
        end else begin
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            for (int c = 0; c < 8; c++) begin
                m_h[c]   <= m_s2[m_sel[c]];
                m_out[c] <= expect_out(m_trig[c], m_trig[8 + c], m_trig[16 + c],
                                       m_s2[m_sel[c]], m_h[c], m_rel[c]);
            end
            m_rel <= '0;
            if (reg_we) begin
                case (reg_addr[4:2])
                    3'd0: begin m_trig <= reg_wdata & 32'h00FF_FFFF; m_rel <= 8'hFF; end
                    3'd1: begin
                        for (int c = 0; c < 4; c++) m_sel[c] <= reg_wdata[c*8 +: 8];
                        m_rel[3:0] <= 4'hF;
                    end
                    3'd2: begin
                        for (int c = 0; c < 4; c++) m_sel[4 + c] <= reg_wdata[c*8 +: 8];
                        m_rel[7:4] <= 4'hF;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model, one check per cycle
    always @(negedge clk) begin
        if (live && !done) begin
            for (int c = 0; c < 8; c++)
                if (irq_out[c] !== m_out[c]) begin
                    $display("FAIL %s: channel %0d actual %b expected %b at %0t",
                             mode_tag(c), c, irq_out[c], m_out[c], $time);
                    n_fail++;
                end
            n_checks++;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata, exp, tag);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst = 1'b0;
        step(1);
        live = 1;
        // R1 reset state
        chk({24'd0, irq_out}, 32'd0, "R1 irq after reset");
        rd(5'h00, 32'd0, "R1 trig reset");
        rd(5'h04, 32'd0, "R1 sel03 reset");
        rd(5'h08, 32'd0, "R1 sel47 reset");
        rd(5'h0C, 32'd0, "R1 filt reset");
        // R2 trigger register width
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'h00FF_FFFF, "R2 trig upper bits");
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h1122_3344);
        rd(5'h04, 32'h1122_3344, "R2 sel03 readback");
        // R4 unmapped offsets
        rd(5'h10, 32'd0, "R4 off 0x10");
        rd(5'h14, 32'd0, "R4 off 0x14");
        rd(5'h1C, 32'd0, "R4 off 0x1C");
        // R3 filter register, no effect on level output
        wr(5'h0C, 32'hA5A5_5A5A);
        rd(5'h0C, 32'hA5A5_5A5A, "R3 filt readback");
        // R2 field placement: ch4..7 -> pads 10,20,30,40; ch0..3 -> 0,1,2,3
        wr(5'h04, {8'd3, 8'd2, 8'd1, 8'd0});
        wr(5'h08, {8'd40, 8'd30, 8'd20, 8'd10});
        pad_in[30] = 1'b1;
        step(4);
        chk({24'd0, irq_out}, 32'h40, "R2 ch6 routes pad 30");
        pad_in[30] = 1'b0;
        pad_in[0] = 1'b1;
        step(3);
        chk({31'd0, irq_out[0]}, 32'd1, "R3 R5 level follows pad 0 with filter set");
        pad_in[0] = 1'b0;
        step(3);
        // R6 level low on ch1 (pad 1 low)
        wr(5'h00, 32'h0002_0000);
        step(1);
        chk({31'd0, irq_out[1]}, 32'd1, "R6 level low");
        // R7 rising on ch3 from pad 200, exact latency
        wr(5'h04, {8'd200, 8'd2, 8'd1, 8'd0});
        wr(5'h00, 32'h0000_0008);
        step(3);
        pad_in[200] = 1'b1;
        step(2);
        chk({31'd0, irq_out[3]}, 32'd0, "R7 not before third edge");
        step(1);
        chk({31'd0, irq_out[3]}, 32'd1, "R7 pulse on third edge");
        step(1);
        chk({31'd0, irq_out[3]}, 32'd0, "R7 single cycle");
        // R8 falling on ch3
        wr(5'h00, 32'h0008_0008);
        step(2);
        pad_in[200] = 1'b0;
        step(3);
        chk({31'd0, irq_out[3]}, 32'd1, "R8 falling pulse");
        step(1);
        chk({31'd0, irq_out[3]}, 32'd0, "R8 single cycle");
        // R9 both-edges on ch5 (pad 20), edge and invert set too
        wr(5'h00, 32'h0020_2020);
        step(2);
        pad_in[20] = 1'b1;
        step(3);
        chk({31'd0, irq_out[5]}, 32'd1, "R9 rise pulse");
        step(1);
        chk({31'd0, irq_out[5]}, 32'd0, "R9 single cycle");
        pad_in[20] = 1'b0;
        step(3);
        chk({31'd0, irq_out[5]}, 32'd1, "R9 fall pulse despite invert");
        // R10 reselect ch2 from low pad 2 to high pad 11 in edge mode
        wr(5'h00, 32'h0000_0004);
        pad_in[11] = 1'b1;
        step(4);
        wr(5'h04, {8'd200, 8'd11, 8'd1, 8'd0});
        for (int k = 0; k < 4; k++) begin
            chk({31'd0, irq_out[2]}, 32'd0, "R10 no spurious pulse");
            step(1);
        end
        // R11 shared pad 7: ch0 level high, ch1 level low
        wr(5'h04, {8'd200, 8'd11, 8'd7, 8'd7});
        wr(5'h00, 32'h0002_0000);
        pad_in[7] = 1'b1;
        step(3);
        chk({30'd0, irq_out[1:0]}, 32'd1, "R11 shared pad high");
        pad_in[7] = 1'b0;
        step(3);
        chk({30'd0, irq_out[1:0]}, 32'd2, "R11 shared pad low");
        // Random phase, continuously compared with the model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if ($urandom % 40 == 0) begin
                case ($urandom % 3)
                    0: wr(5'h00, $urandom);
                    1: wr(5'h04, {4{4'd0, 4'($urandom)}} ^ {8'($urandom % 16), 24'd0});
                    default: wr(5'h08, {4'd0, 4'($urandom), 4'd0, 4'($urandom),
                                        4'd0, 4'($urandom), 4'd0, 4'($urandom)});
                endcase
            end else begin
                pad_in[15:0] = pad_in[15:0] ^ (16'($urandom) & 16'($urandom));
                step(1);
            end
        end
        step(4);
        finish_run();
    end
endmodule